// File: doc/BRIEF.md
# Bit-Manipulation Basic ALU

This block is the combinational execute stage for the basic bit-manipulation group of a 64-bit integer core. A decoder outside the block selects one operation with a 5-bit code and supplies two 64-bit register operands and a 6-bit immediate shift amount. The block returns the 64-bit result and a flag that tells the core to take an illegal-instruction trap.

The group covers bit counting (leading zeros, trailing zeros, set bits), inverted logic (and-not, or-not, xnor), signed and unsigned minimum and maximum, sign and zero extension, rotates, byte reversal and a per-byte or-combine. Word variants of the counts and rotates work only on the low 32 bits. A single enable input turns the whole group off, for cores built without the extension. Decode, register file and pipeline are outside the block.

Top module: `bm_alu`

## Requirements
- R1: Code 0 returns the number of leading zero bits of opnd_a, and code 1 returns the number of trailing zero bits. Both return 64 when opnd_a is zero.
- R2: Code 3 counts leading zeros and code 4 counts trailing zeros within opnd_a[31:0] only. Both return 32 when that low word is zero.
- R3: Code 2 returns the number of set bits in opnd_a. Code 5 counts the set bits in opnd_a[31:0] only.
- R4: Code 6 returns a & ~b, code 7 returns a | ~b, and code 8 returns ~(a ^ b).
- R5: Code 9 returns the signed minimum of the operands and code 10 the signed maximum. Code 11 returns the unsigned minimum and code 12 the unsigned maximum.
- R6: Code 13 copies bit 7 of a into bits 63:8, code 14 copies bit 15 into bits 63:16, and code 15 clears bits 63:16.
- R7: Code 16 rotates a left and code 17 rotates it right, both by opnd_b[5:0]. Code 18 rotates a right by imm_sh.
- R8: Code 19 rotates a[31:0] left and code 20 rotates it right, both by opnd_b[4:0]. Code 21 rotates a[31:0] right by imm_sh[4:0]. Each word rotate sign-extends bit 31 of the rotated word into bits 63:32.
- R9: Code 22 reverses the byte order of all eight bytes of a, so that byte 0 becomes byte 7.
- R10: Code 23 sets every bit of a result byte to one when the matching byte of a is non-zero, and sets the byte to zero otherwise.
- R11: illegal_insn is 1 when ext_en is 0 or op_sel is 24 to 31, and 0 otherwise. While illegal_insn is 1, res is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_en | input | 1 | Enable for the bit-manipulation group |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 64 | First source operand |
| opnd_b | input | 64 | Second source operand; also the register rotate amount |
| imm_sh | input | 6 | Immediate rotate amount |
| res | output | 64 | Result, zero when illegal |
| illegal_insn | output | 1 | Illegal-instruction indication |

## Verification
The block holds no state, so res and illegal_insn are due in the same cycle that the inputs change, with no register in the path. The bench drives every vector just after a falling clock edge and compares both outputs one nanosecond later, well before the next rising edge. It sweeps all 32 codes, with the enable both low and high, across walking-one, zero, all-ones, sign-boundary and pseudo-random operands. Some of the random operands have a zeroed low word or zeroed bytes, so that the zero cases of the word counts and of the or-combine are reached.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int BM_XLEN = 64;
  localparam int BM_WLEN = BM_XLEN / 2;
  localparam int CNT_W   = $clog2(BM_XLEN) + 1;
  localparam int SH_W    = $clog2(BM_XLEN);
  localparam int SHW_W   = $clog2(BM_WLEN);
  localparam int NBYTES  = BM_XLEN / 8;

  typedef enum logic [4:0] {
    OP_CLZ = 5'd0,  OP_CTZ = 5'd1,  OP_CPOP = 5'd2,  OP_CLZW = 5'd3,
    OP_CTZW = 5'd4, OP_CPOPW = 5'd5, OP_ANDN = 5'd6, OP_ORN = 5'd7,
    OP_XNOR = 5'd8, OP_MIN = 5'd9,  OP_MAX = 5'd10,  OP_MINU = 5'd11,
    OP_MAXU = 5'd12, OP_SEXTB = 5'd13, OP_SEXTH = 5'd14, OP_ZEXTH = 5'd15,
    OP_ROL = 5'd16, OP_ROR = 5'd17, OP_RORI = 5'd18, OP_ROLW = 5'd19,
    OP_RORW = 5'd20, OP_RORIW = 5'd21, OP_REV8 = 5'd22, OP_ORCB = 5'd23
  } op_e;

  localparam logic [4:0] OP_LAST = 5'd23;

  function automatic logic [CNT_W-1:0] lead_zeros(input logic [BM_XLEN-1:0] v);
    logic [CNT_W-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = BM_XLEN - 1; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + CNT_W'(1);
    end
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] trail_zeros(input logic [BM_XLEN-1:0] v);
    logic [CNT_W-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = 0; i < BM_XLEN; i++) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + CNT_W'(1);
    end
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] ones_count(input logic [BM_XLEN-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < BM_XLEN; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [BM_XLEN-1:0] rot_l(input logic [BM_XLEN-1:0] v,
                                               input logic [SH_W-1:0] s);
    logic [2*BM_XLEN-1:0] d;
    d = {v, v} << s;
    return d[2*BM_XLEN-1:BM_XLEN];
  endfunction

  function automatic logic [BM_XLEN-1:0] rot_r(input logic [BM_XLEN-1:0] v,
                                               input logic [SH_W-1:0] s);
    logic [2*BM_XLEN-1:0] d;
    d = {v, v} >> s;
    return d[BM_XLEN-1:0];
  endfunction

  function automatic logic [BM_XLEN-1:0] rot_lw(input logic [BM_WLEN-1:0] v,
                                                input logic [SHW_W-1:0] s);
    logic [2*BM_WLEN-1:0] d;
    d = {v, v} << s;
    return {{BM_WLEN{d[2*BM_WLEN-1]}}, d[2*BM_WLEN-1:BM_WLEN]};
  endfunction

  function automatic logic [BM_XLEN-1:0] rot_rw(input logic [BM_WLEN-1:0] v,
                                                input logic [SHW_W-1:0] s);
    logic [2*BM_WLEN-1:0] d;
    d = {v, v} >> s;
    return {{BM_WLEN{d[BM_WLEN-1]}}, d[BM_WLEN-1:0]};
  endfunction
endpackage

// File: rtl/bm_count.sv
module bm_count
  import bm_pkg::*;
(
  input  logic [BM_XLEN-1:0] a,
  output logic [CNT_W-1:0]   clz,
  output logic [CNT_W-1:0]   ctz,
  output logic [CNT_W-1:0]   cpop,
  output logic [CNT_W-1:0]   clzw,
  output logic [CNT_W-1:0]   ctzw,
  output logic [CNT_W-1:0]   cpopw
);
  assign clz   = lead_zeros(a);
  assign ctz   = trail_zeros(a);
  assign cpop  = ones_count(a);
  // word forms: pad the unused half so the full-width counters stop at 32
  assign clzw  = lead_zeros({a[BM_WLEN-1:0], {BM_WLEN{1'b1}}});
  assign ctzw  = trail_zeros({{BM_WLEN{1'b1}}, a[BM_WLEN-1:0]});
  assign cpopw = ones_count({{BM_WLEN{1'b0}}, a[BM_WLEN-1:0]});

  always_comb begin
    // R1
    clz_zero_chk: assert ((clz == CNT_W'(BM_XLEN)) == (a == '0));
    // R1
    ctz_zero_chk: assert ((ctz == CNT_W'(BM_XLEN)) == (a == '0));
    // R2
    wcount_range_chk: assert (clzw <= CNT_W'(BM_WLEN) && ctzw <= CNT_W'(BM_WLEN));
    // R3
    cpopw_bound_chk: assert (cpopw <= cpop);
  end
endmodule

// File: rtl/bm_rotate.sv
module bm_rotate
  import bm_pkg::*;
(
  input  logic [BM_XLEN-1:0] a,
  input  logic [SH_W-1:0]    reg_amt,
  input  logic [SH_W-1:0]    imm_amt,
  output logic [BM_XLEN-1:0] rol,
  output logic [BM_XLEN-1:0] ror,
  output logic [BM_XLEN-1:0] rori,
  output logic [BM_XLEN-1:0] rolw,
  output logic [BM_XLEN-1:0] rorw,
  output logic [BM_XLEN-1:0] roriw
);
  assign rol   = rot_l(a, reg_amt);
  assign ror   = rot_r(a, reg_amt);
  assign rori  = rot_r(a, imm_amt);
  assign rolw  = rot_lw(a[BM_WLEN-1:0], reg_amt[SHW_W-1:0]);
  assign rorw  = rot_rw(a[BM_WLEN-1:0], reg_amt[SHW_W-1:0]);
  assign roriw = rot_rw(a[BM_WLEN-1:0], imm_amt[SHW_W-1:0]);

  always_comb begin
    // R7
    rot_ones_chk: assert ($countones(rol) == $countones(a) && $countones(ror) == $countones(a));
    // R8
    rotw_ones_chk: assert ($countones(rorw[BM_WLEN-1:0]) == $countones(a[BM_WLEN-1:0]));
  end
endmodule

// File: rtl/bm_misc.sv
module bm_misc
  import bm_pkg::*;
(
  input  logic [BM_XLEN-1:0] a,
  input  logic [BM_XLEN-1:0] b,
  output logic [BM_XLEN-1:0] andn,
  output logic [BM_XLEN-1:0] orn,
  output logic [BM_XLEN-1:0] xnor_r,
  output logic [BM_XLEN-1:0] smin,
  output logic [BM_XLEN-1:0] smax,
  output logic [BM_XLEN-1:0] umin,
  output logic [BM_XLEN-1:0] umax,
  output logic [BM_XLEN-1:0] sextb,
  output logic [BM_XLEN-1:0] sexth,
  output logic [BM_XLEN-1:0] zexth,
  output logic [BM_XLEN-1:0] rev,
  output logic [BM_XLEN-1:0] orc
);
  logic s_lt, u_lt;

  assign andn   = a & ~b;
  assign orn    = a | ~b;
  assign xnor_r = ~(a ^ b);

  assign s_lt = $signed(a) < $signed(b);
  assign u_lt = a < b;
  assign smin = s_lt ? a : b;
  assign smax = s_lt ? b : a;
  assign umin = u_lt ? a : b;
  assign umax = u_lt ? b : a;

  assign sextb = {{(BM_XLEN-8){a[7]}}, a[7:0]};
  assign sexth = {{(BM_XLEN-16){a[15]}}, a[15:0]};
  assign zexth = {{(BM_XLEN-16){1'b0}}, a[15:0]};

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign rev[8*g +: 8] = a[8*(NBYTES-1-g) +: 8];
    assign orc[8*g +: 8] = {8{|a[8*g +: 8]}};
  end

  always_comb begin
    // R5
    sminmax_chk: assert ($signed(smin) <= $signed(smax));
    // R5
    uminmax_chk: assert (umin <= umax);
    // R10
    orc_zero_chk: assert ((orc == '0) == (a == '0));
    // R9
    rev_ones_chk: assert ($countones(rev) == $countones(a));
  end
endmodule

// File: rtl/bm_alu.sv
module bm_alu
  import bm_pkg::*;
(
  input  logic                ext_en,
  input  logic [4:0]          op_sel,
  input  logic [BM_XLEN-1:0]  opnd_a,
  input  logic [BM_XLEN-1:0]  opnd_b,
  input  logic [SH_W-1:0]     imm_sh,
  output logic [BM_XLEN-1:0]  res,
  output logic                illegal_insn
);
  localparam int PAD = BM_XLEN - CNT_W;

  logic [CNT_W-1:0] clz, ctz, cpop, clzw, ctzw, cpopw;
  logic [BM_XLEN-1:0] rol, ror, rori, rolw, rorw, roriw;
  logic [BM_XLEN-1:0] andn, orn, xnor_r, smin, smax, umin, umax;
  logic [BM_XLEN-1:0] sextb, sexth, zexth, rev, orc;
  logic [BM_XLEN-1:0] raw;
  logic               code_bad;
  op_e                opc;

  bm_count u_count (
    .a(opnd_a), .clz(clz), .ctz(ctz), .cpop(cpop),
    .clzw(clzw), .ctzw(ctzw), .cpopw(cpopw)
  );

  bm_rotate u_rot (
    .a(opnd_a), .reg_amt(opnd_b[SH_W-1:0]), .imm_amt(imm_sh),
    .rol(rol), .ror(ror), .rori(rori), .rolw(rolw), .rorw(rorw), .roriw(roriw)
  );

  bm_misc u_misc (
    .a(opnd_a), .b(opnd_b), .andn(andn), .orn(orn), .xnor_r(xnor_r),
    .smin(smin), .smax(smax), .umin(umin), .umax(umax),
    .sextb(sextb), .sexth(sexth), .zexth(zexth), .rev(rev), .orc(orc)
  );

  assign opc = op_e'(op_sel);

  always_comb begin
    raw = '0;
    case (opc)
      OP_CLZ:   raw = {{PAD{1'b0}}, clz};
      OP_CTZ:   raw = {{PAD{1'b0}}, ctz};
      OP_CPOP:  raw = {{PAD{1'b0}}, cpop};
      OP_CLZW:  raw = {{PAD{1'b0}}, clzw};
      OP_CTZW:  raw = {{PAD{1'b0}}, ctzw};
      OP_CPOPW: raw = {{PAD{1'b0}}, cpopw};
      OP_ANDN:  raw = andn;
      OP_ORN:   raw = orn;
      OP_XNOR:  raw = xnor_r;
      OP_MIN:   raw = smin;
      OP_MAX:   raw = smax;
      OP_MINU:  raw = umin;
      OP_MAXU:  raw = umax;
      OP_SEXTB: raw = sextb;
      OP_SEXTH: raw = sexth;
      OP_ZEXTH: raw = zexth;
      OP_ROL:   raw = rol;
      OP_ROR:   raw = ror;
      OP_RORI:  raw = rori;
      OP_ROLW:  raw = rolw;
      OP_RORW:  raw = rorw;
      OP_RORIW: raw = roriw;
      OP_REV8:  raw = rev;
      OP_ORCB:  raw = orc;
      default:  raw = '0;
    endcase
  end

  assign code_bad     = op_sel > OP_LAST;
  assign illegal_insn = !ext_en || code_bad;
  assign res          = illegal_insn ? '0 : raw;

  always_comb begin
    // R11
    illegal_zero_chk: assert (!illegal_insn || res == '0);
    // R11
    disabled_illegal_chk: assert (ext_en || illegal_insn);
  end
endmodule

// File: tb/sim_bm_alu.sv
module sim_bm_alu;
  logic        clk = 1'b0;
  logic        ext_en = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [5:0]  imm_sh = '0;
  logic [63:0] res;
  logic        illegal_insn;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bm_alu u0 (
    .ext_en(ext_en), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm_sh(imm_sh), .res(res), .illegal_insn(illegal_insn)
  );

  function automatic string req_tag(input int op, input logic en);
    if (!en || op > 23) return "R11";
    case (op)
      0, 1:        return "R1";
      3, 4:        return "R2";
      2, 5:        return "R3";
      6, 7, 8:     return "R4";
      9, 10, 11, 12: return "R5";
      13, 14, 15:  return "R6";
      16, 17, 18:  return "R7";
      19, 20, 21:  return "R8";
      22:          return "R9";
      default:     return "R10";
    endcase
  endfunction

  function automatic logic [63:0] model(input int op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] imm);
    logic [63:0] r;
    logic [31:0] w;
    int n, s;
    r = '0;
    case (op)
      0: begin n = 64; for (int i = 0; i < 64; i++) if (a[i]) n = 63 - i; r = 64'(n); end
      1: begin n = 64; for (int i = 63; i >= 0; i--) if (a[i]) n = i; r = 64'(n); end
      2: begin n = 0; for (int i = 0; i < 64; i++) n += int'(a[i]); r = 64'(n); end
      3: begin n = 32; for (int i = 0; i < 32; i++) if (a[i]) n = 31 - i; r = 64'(n); end
      4: begin n = 32; for (int i = 31; i >= 0; i--) if (a[i]) n = i; r = 64'(n); end
      5: begin n = 0; for (int i = 0; i < 32; i++) n += int'(a[i]); r = 64'(n); end
      6: for (int i = 0; i < 64; i++) r[i] = a[i] && !b[i];
      7: for (int i = 0; i < 64; i++) r[i] = a[i] || !b[i];
      8: for (int i = 0; i < 64; i++) r[i] = (a[i] == b[i]);
      9:  r = ($signed(a) > $signed(b)) ? b : a;
      10: r = ($signed(a) > $signed(b)) ? a : b;
      11: r = (a > b) ? b : a;
      12: r = (a > b) ? a : b;
      13: begin r = a & 64'hFF; if (a[7]) r = r | 64'hFFFF_FFFF_FFFF_FF00; end
      14: begin r = a & 64'hFFFF; if (a[15]) r = r | 64'hFFFF_FFFF_FFFF_0000; end
      15: r = a & 64'hFFFF;
      16: begin s = int'(b[5:0]); for (int i = 0; i < 64; i++) r[(i + s) % 64] = a[i]; end
      17: begin s = int'(b[5:0]); for (int i = 0; i < 64; i++) r[i] = a[(i + s) % 64]; end
      18: begin s = int'(imm); for (int i = 0; i < 64; i++) r[i] = a[(i + s) % 64]; end
      19, 20, 21: begin
        s = (op == 21) ? int'(imm[4:0]) : int'(b[4:0]);
        for (int i = 0; i < 32; i++) begin
          if (op == 19) w[(i + s) % 32] = a[i];
          else w[i] = a[(i + s) % 32];
        end
        r = {{32{w[31]}}, w};
      end
      22: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
      23: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic apply(input int op, input logic en, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] imm);
    logic [63:0] exp_r;
    logic exp_i;
    @(negedge clk);
    op_sel = 5'(op);
    ext_en = en;
    opnd_a = a;
    opnd_b = b;
    imm_sh = imm;
    exp_i = !en || (op > 23);
    exp_r = exp_i ? 64'd0 : model(op, a, b, imm);
    #1;
    n_vec++;
    if (res !== exp_r || illegal_insn !== exp_i) begin
      n_bad++;
      $display("FAIL %s op=%0d en=%0b a=%h b=%h imm=%0d: res=%h ill=%0b expected res=%h ill=%0b",
               req_tag(op, en), op, en, a, b, imm, res, illegal_insn, exp_r, exp_i);
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: ran %0d cycles, expected fewer than 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [63:0] st, a, b;
    logic [5:0]  imm;
    st = 64'h9E37_79B9_7F4A_7C15;
    // R11: idle state with the group disabled reports illegal and zero
    apply(0, 1'b0, 64'd0, 64'd0, 6'd0);
    for (int k = 0; k < 140; k++) begin
      if (k < 64) begin
        a = 64'd1 << k; b = 64'(k); imm = 6'(k);
      end else if (k == 64) begin
        a = '0; b = '0; imm = '0;
      end else if (k == 65) begin
        a = '1; b = '1; imm = 6'd63;
      end else if (k == 66) begin
        a = 64'h8000_0000_0000_0000; b = 64'h7FFF_FFFF_FFFF_FFFF; imm = 6'd32;
      end else if (k == 67) begin
        a = 64'hFFFF_FFFF_8000_0000; b = 64'h0000_0000_0000_0021; imm = 6'd33;
      end else if (k == 68) begin
        a = 64'h0123_4567_89AB_CDEF; b = a; imm = 6'd31;
      end else begin
        st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
        a = st;
        st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
        b = st;
        imm = b[11:6];
        if (k % 4 == 0) a = a & 64'hFFFF_FFFF_0000_0000;
        if (k % 5 == 0) a = a & 64'hFF00_00FF_0000_FF00;
      end
      // R1..R10 with ext_en high, R11 with ext_en low and codes 24..31
      for (int op = 0; op < 32; op++) begin
        apply(op, 1'b1, a, b, imm);
        apply(op, 1'b0, a, b, imm);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule